// File: doc/BRIEF.md
# Bit-Addressed Register Load Sequencer

This block is the host-facing register front end of an asynchronous serial controller. The host writes one bit per cycle, giving a 5-bit bit address and a single data bit, and reads back 8-bit status groups. Addresses 0 to 10 form one shared data window. Four load flags decide where a bit in that window lands: the control register, the interval register, the receive and/or transmit rate registers, or the transmit buffer when no flag is set.

Writing the final bit of a register retires its flag. A host that streams bits 0..7 (or 0..10 for the rates) repeatedly therefore walks through the registers in priority order. Addresses above the window set or clear the load flags, drive the request-to-send enable and the break request, write four interrupt enables, and issue a soft reset.

The serial engines are outside this block. They report through strobes: a received byte, the transmit buffer being taken, a timer tick, and the shift-empty, clear-to-send and data-set-ready levels. The block returns the transmit request and timer reload pulses, the register contents, the read groups and one combined interrupt.

Top module: `bitwin_regfile`

## Requirements
- R1: After rst_n is released:
  - all four load flags are set;
  - all interrupt enables, rts_en and brk_req are 0;
  - irq is 0;
  - the transmit buffer reads empty;
  - the receive-loaded flag is 0.
- R2: A bit write to addresses 0..10 goes to one destination, chosen in this order: control if its flag (flag 3) is set; else interval (flag 2); else rate if either rate flag (flag 1 receive, flag 0 transmit) is set; else the transmit buffer. Bit n of the address writes bit n of that register. Control, interval and transmit buffer ignore addresses 8..10.
- R3: Writing address 7 while the control register is selected clears the control flag.
- R4: Writing address 7 while the interval register is selected clears the interval flag. tmr_reload is high for exactly the one cycle after that write.
- R5: While a rate is selected:
  - addresses 0..9 write the 10-bit divisor;
  - address 10 writes the divide-by-8 bit and clears both rate flags;
  - each rate register is written only when its own flag is set, so both load together when both flags are set.
- R6: Writing address 7 while the transmit buffer is selected marks the buffer full. tx_req is high for exactly the one cycle after that write.
- R7: Addresses 11, 12, 13 and 14 write the data bit into flags 0, 1, 2 and 3. Writing 0 to address 13 while flag 2 is set gives a one-cycle tmr_reload. Writing 0 to address 13 while flag 2 is already clear gives no pulse.
- R8: Addresses 16 and 17 write rts_en and brk_req. Addresses 18, 19, 20 and 21 write the receive, transmit, timer and status-change enables (enable bits 0..3).
  - Writing 18 also clears the receive-loaded and overrun flags.
  - Writing 20 clears timer-elapsed and timer-error.
  - Writing 21 clears status-change.
- R9: Writing address 31 sets all load flags, clears all enables, rts_en and brk_req, marks the transmit buffer empty, and clears receive-loaded and overrun.
- R10: Read group 2 is {shift-empty, buffer-empty, receive-loaded, status-change AND en3, timer-elapsed AND en2, 0, buffer-empty AND en1, receive-loaded AND en0}, listed from bit 7 down to bit 0.
- R11: Read group 3 is {irq, any load flag set, status-change, CTS, DSR, rts_en, timer-elapsed, timer-error}, listed from bit 7 down to bit 0.
- R12: irq is the OR of the four enabled flags in R10 (bits 4, 3, 1 and 0 of group 2).
- R13: Status flags:
  - rx_push sets receive-loaded and stores rx_byte; a push while receive-loaded is already set also sets overrun;
  - tx_take marks the buffer empty;
  - tmr_tick sets timer-elapsed, or sets timer-error if timer-elapsed is already set;
  - a change on cts_in or dsr_in sets status-change at the next edge.
- R14: Read group 0 is the last received byte. Read group 1 has overrun in bits 3 and 1 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bit write strobe |
| wr_addr | input | 5 | Bit address |
| wr_data | input | 1 | Bit value |
| rd_grp | input | 2 | Read group select |
| rd_data | output | 8 | Selected read group |
| irq | output | 1 | Combined interrupt |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | Transmitter took the buffer |
| xsr_empty | input | 1 | Transmit shifter empty level |
| tmr_tick | input | 1 | Interval timer expiry |
| cts_in | input | 1 | Clear-to-send level |
| dsr_in | input | 1 | Data-set-ready level |
| rts_en | output | 1 | Request-to-send enable |
| brk_req | output | 1 | Break request |
| tx_req | output | 1 | One-cycle transmit request |
| tmr_reload | output | 1 | One-cycle timer reload |
| ctrl_q | output | 8 | Control register |
| intv_q | output | 8 | Interval register |
| rx_rate_q | output | RATE_W | Receive divisor |
| rx_div8_q | output | 1 | Receive divide-by-8 |
| tx_rate_q | output | RATE_W | Transmit divisor |
| tx_div8_q | output | 1 | Transmit divide-by-8 |
| txbuf_q | output | 8 | Transmit buffer |

## Verification
Writes, flag changes and status strobes take effect at the clock edge that samples them. Register outputs and the read groups are therefore due at the next falling edge, because the read mux and irq are combinational. The bench drives on a falling edge and checks at the following falling edge, reading a group 1 ns after setting rd_grp.

The two pulses are registered. They must be seen high at the falling edge just after the write, and low one cycle later. A CTS/DSR change is registered once before it sets status-change, so it is checked one full cycle after the level moves.

// File: rtl/bitwin_pkg.sv
package bitwin_pkg;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NFLAG  = 4;

   typedef enum logic [1:0] {
      DST_CTRL  = 2'd0,
      DST_INTV  = 2'd1,
      DST_RATE  = 2'd2,
      DST_TXBUF = 2'd3
   } dest_e;

   localparam logic [ADDR_W-1:0] A_BYTE_LAST = 5'd7;
   localparam logic [ADDR_W-1:0] A_WIN_LAST  = 5'd10;
   localparam logic [ADDR_W-1:0] A_LD_TXR    = 5'd11;
   localparam logic [ADDR_W-1:0] A_LD_RXR    = 5'd12;
   localparam logic [ADDR_W-1:0] A_LD_INTV   = 5'd13;
   localparam logic [ADDR_W-1:0] A_LD_CTRL   = 5'd14;
   localparam logic [ADDR_W-1:0] A_RTS       = 5'd16;
   localparam logic [ADDR_W-1:0] A_BRK       = 5'd17;
   localparam logic [ADDR_W-1:0] A_EN_RX     = 5'd18;
   localparam logic [ADDR_W-1:0] A_EN_TX     = 5'd19;
   localparam logic [ADDR_W-1:0] A_EN_TMR    = 5'd20;
   localparam logic [ADDR_W-1:0] A_EN_DSC    = 5'd21;
   localparam logic [ADDR_W-1:0] A_SRST      = 5'd31;

   localparam int unsigned F_TXR  = 0;
   localparam int unsigned F_RXR  = 1;
   localparam int unsigned F_INTV = 2;
   localparam int unsigned F_CTRL = 3;
endpackage

// File: rtl/bitwin_route.sv
module bitwin_route
   import bitwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_data,
   output logic [NFLAG-1:0]  ld_flags,
   output dest_e             dest,
   output logic              buf_fill,
   output logic              tx_req,
   output logic              tmr_reload
);
   logic in_win;
   logic last_byte;

   always_comb begin
      if (ld_flags[F_CTRL])                          dest = DST_CTRL;
      else if (ld_flags[F_INTV])                     dest = DST_INTV;
      else if (ld_flags[F_RXR] || ld_flags[F_TXR])   dest = DST_RATE;
      else                                           dest = DST_TXBUF;
   end

   assign in_win    = wr_en && (wr_addr <= A_WIN_LAST);
   assign last_byte = (wr_addr == A_BYTE_LAST);
   assign buf_fill  = in_win && (dest == DST_TXBUF) && last_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_flags   <= '1;
         tx_req     <= 1'b0;
         tmr_reload <= 1'b0;
      end else begin
         tx_req     <= 1'b0;
         tmr_reload <= 1'b0;
         if (in_win) begin
            case (dest)
               DST_CTRL:  if (last_byte) ld_flags[F_CTRL] <= 1'b0;
               DST_INTV:  if (last_byte) begin
                             ld_flags[F_INTV] <= 1'b0;
                             tmr_reload       <= 1'b1;
                          end
               DST_RATE:  if (wr_addr == A_WIN_LAST) begin
                             ld_flags[F_RXR] <= 1'b0;
                             ld_flags[F_TXR] <= 1'b0;
                          end
               default:   if (last_byte) tx_req <= 1'b1;
            endcase
         end else if (wr_en) begin
            case (wr_addr)
               A_LD_TXR:  ld_flags[F_TXR]  <= wr_data;
               A_LD_RXR:  ld_flags[F_RXR]  <= wr_data;
               A_LD_INTV: begin
                  ld_flags[F_INTV] <= wr_data;
                  if (!wr_data && ld_flags[F_INTV]) tmr_reload <= 1'b1;
               end
               A_LD_CTRL: ld_flags[F_CTRL] <= wr_data;
               A_SRST:    ld_flags         <= '1;
               default:   ;
            endcase
         end
      end
   end

   a_r6_txreq_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);
   a_r4_reload_single: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_reload |=> !tmr_reload);
   a_r3_ctrl_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_BYTE_LAST && ld_flags[F_CTRL]) |=> !ld_flags[F_CTRL]);
   a_r9_flags_after_srst: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_SRST) |=> (ld_flags == '1));
endmodule

// File: rtl/bitwin_loadregs.sv
module bitwin_loadregs
   import bitwin_pkg::*;
#(
   parameter int unsigned RATE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_data,
   input  dest_e             dest,
   input  logic [NFLAG-1:0]  ld_flags,
   output logic [BYTE_W-1:0] ctrl_q,
   output logic [BYTE_W-1:0] intv_q,
   output logic [BYTE_W-1:0] txbuf_q,
   output logic [RATE_W-1:0] rx_rate_q,
   output logic              rx_div8_q,
   output logic [RATE_W-1:0] tx_rate_q,
   output logic              tx_div8_q
);
   localparam int unsigned DIV8_BIT = A_WIN_LAST;

   if (RATE_W < 1 || RATE_W > DIV8_BIT) begin : g_bad_rate_w
      $error("RATE_W must lie in 1..10");
   end

   logic rx_sel;
   logic tx_sel;
   assign rx_sel = wr_en && (dest == DST_RATE) && ld_flags[F_RXR];
   assign tx_sel = wr_en && (dest == DST_RATE) && ld_flags[F_TXR];

   for (genvar g = 0; g < BYTE_W; g++) begin : g_byte
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctrl_q[g]  <= 1'b0;
            intv_q[g]  <= 1'b0;
            txbuf_q[g] <= 1'b0;
         end else if (hit) begin
            if (dest == DST_CTRL)  ctrl_q[g]  <= wr_data;
            if (dest == DST_INTV)  intv_q[g]  <= wr_data;
            if (dest == DST_TXBUF) txbuf_q[g] <= wr_data;
         end
      end
   end

   for (genvar g = 0; g < RATE_W; g++) begin : g_rate
      logic hit;
      assign hit = (wr_addr == ADDR_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rx_rate_q[g] <= 1'b0;
            tx_rate_q[g] <= 1'b0;
         end else if (hit) begin
            if (rx_sel) rx_rate_q[g] <= wr_data;
            if (tx_sel) tx_rate_q[g] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_div8_q <= 1'b0;
         tx_div8_q <= 1'b0;
      end else if (wr_addr == A_WIN_LAST) begin
         if (rx_sel) rx_div8_q <= wr_data;
         if (tx_sel) tx_div8_q <= wr_data;
      end
   end

   a_r5_rate_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_flags[F_RXR] || !wr_en) |=> $stable(rx_rate_q));
endmodule

// File: rtl/bitwin_status.sv
module bitwin_status
   import bitwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_data,
   input  logic [NFLAG-1:0]  ld_flags,
   input  logic              buf_fill,
   input  logic              rx_push,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              tx_take,
   input  logic              xsr_empty,
   input  logic              tmr_tick,
   input  logic              cts_in,
   input  logic              dsr_in,
   input  logic [1:0]        rd_grp,
   output logic [BYTE_W-1:0] rd_data,
   output logic              irq,
   output logic              rts_en,
   output logic              brk_req
);
   logic [3:0]        ien;
   logic [BYTE_W-1:0] rx_hold;
   logic              rx_loaded, overrun, buf_empty;
   logic              tmr_elapsed, tmr_err, dsch;
   logic              cts_q, dsr_q;
   logic [3:0]        pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien         <= '0;
         rts_en      <= 1'b0;
         brk_req     <= 1'b0;
         rx_hold     <= '0;
         rx_loaded   <= 1'b0;
         overrun     <= 1'b0;
         buf_empty   <= 1'b1;
         tmr_elapsed <= 1'b0;
         tmr_err     <= 1'b0;
         dsch        <= 1'b0;
         cts_q       <= 1'b0;
         dsr_q       <= 1'b0;
      end else begin
         if (wr_en) begin
            case (wr_addr)
               A_RTS:    rts_en  <= wr_data;
               A_BRK:    brk_req <= wr_data;
               A_EN_RX:  begin ien[0] <= wr_data; rx_loaded <= 1'b0; overrun <= 1'b0; end
               A_EN_TX:  ien[1] <= wr_data;
               A_EN_TMR: begin ien[2] <= wr_data; tmr_elapsed <= 1'b0; tmr_err <= 1'b0; end
               A_EN_DSC: begin ien[3] <= wr_data; dsch <= 1'b0; end
               A_SRST: begin
                  ien       <= '0;
                  rts_en    <= 1'b0;
                  brk_req   <= 1'b0;
                  buf_empty <= 1'b1;
                  rx_loaded <= 1'b0;
                  overrun   <= 1'b0;
               end
               default: ;
            endcase
         end
         if (tx_take)  buf_empty <= 1'b1;
         if (buf_fill) buf_empty <= 1'b0;
         if (rx_push) begin
            rx_hold   <= rx_byte;
            rx_loaded <= 1'b1;
            if (rx_loaded) overrun <= 1'b1;
         end
         if (tmr_tick) begin
            if (tmr_elapsed) tmr_err     <= 1'b1;
            else             tmr_elapsed <= 1'b1;
         end
         cts_q <= cts_in;
         dsr_q <= dsr_in;
         if ((cts_in != cts_q) || (dsr_in != dsr_q)) dsch <= 1'b1;
      end
   end

   assign pend = {dsch & ien[3], tmr_elapsed & ien[2], buf_empty & ien[1], rx_loaded & ien[0]};
   assign irq  = |pend;

   always_comb begin
      case (rd_grp)
         2'd0:    rd_data = rx_hold;
         2'd1:    rd_data = {4'b0000, overrun, 1'b0, overrun, 1'b0};
         2'd2:    rd_data = {xsr_empty, buf_empty, rx_loaded, pend[3], pend[2], 1'b0, pend[1], pend[0]};
         default: rd_data = {irq, |ld_flags, dsch, cts_q, dsr_q, rts_en, tmr_elapsed, tmr_err};
      endcase
   end

   a_r13_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_loaded) |=> overrun);
   a_r13_timer_err: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_tick && tmr_elapsed) |=> tmr_err);
   a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 4'b0000) |-> !irq);
   a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_SRST) |=> (ien == 4'b0000 && !rts_en && !brk_req));
   a_r6_full_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      buf_fill |=> !buf_empty);
endmodule

// File: rtl/bitwin_regfile.sv
module bitwin_regfile
   import bitwin_pkg::*;
#(
   parameter int unsigned RATE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        wr_addr,
   input  logic              wr_data,
   input  logic [1:0]        rd_grp,
   output logic [7:0]        rd_data,
   output logic              irq,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   input  logic              tx_take,
   input  logic              xsr_empty,
   input  logic              tmr_tick,
   input  logic              cts_in,
   input  logic              dsr_in,
   output logic              rts_en,
   output logic              brk_req,
   output logic              tx_req,
   output logic              tmr_reload,
   output logic [7:0]        ctrl_q,
   output logic [7:0]        intv_q,
   output logic [RATE_W-1:0] rx_rate_q,
   output logic              rx_div8_q,
   output logic [RATE_W-1:0] tx_rate_q,
   output logic              tx_div8_q,
   output logic [7:0]        txbuf_q
);
   logic [NFLAG-1:0] ld_flags;
   dest_e            dest;
   logic             buf_fill;

   bitwin_route u_route (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ld_flags(ld_flags), .dest(dest), .buf_fill(buf_fill),
      .tx_req(tx_req), .tmr_reload(tmr_reload)
   );

   bitwin_loadregs #(.RATE_W(RATE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dest(dest), .ld_flags(ld_flags),
      .ctrl_q(ctrl_q), .intv_q(intv_q), .txbuf_q(txbuf_q),
      .rx_rate_q(rx_rate_q), .rx_div8_q(rx_div8_q),
      .tx_rate_q(tx_rate_q), .tx_div8_q(tx_div8_q)
   );

   bitwin_status u_stat (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ld_flags(ld_flags), .buf_fill(buf_fill),
      .rx_push(rx_push), .rx_byte(rx_byte), .tx_take(tx_take), .xsr_empty(xsr_empty),
      .tmr_tick(tmr_tick), .cts_in(cts_in), .dsr_in(dsr_in),
      .rd_grp(rd_grp), .rd_data(rd_data), .irq(irq),
      .rts_en(rts_en), .brk_req(brk_req)
   );
endmodule

// File: tb/tb_bitwin_regfile.sv
`timescale 1ns/1ps
module tb_bitwin_regfile;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, wr_en, wr_data, rx_push, tx_take, xsr_empty, tmr_tick, cts_in, dsr_in;
   logic [4:0] wr_addr;
   logic [1:0] rd_grp;
   logic [7:0] rx_byte, rd_data, ctrl_q, intv_q, txbuf_q;
   logic [9:0] rx_rate_q, tx_rate_q;
   logic irq, rts_en, brk_req, tx_req, tmr_reload, rx_div8_q, tx_div8_q;

   bitwin_regfile dut (.*);

   int checks = 0, errors = 0;
   logic p_tx, p_rl;
   logic [7:0] g;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
      p_tx = tx_req; p_rl = tmr_reload;
   endtask

   task automatic wbyte(logic [7:0] v);
      for (int i = 0; i < 8; i++) wr(5'(i), v[i]);
   endtask

   task automatic wrate(logic [9:0] v, logic d8);
      for (int i = 0; i < 10; i++) wr(5'(i), v[i]);
      wr(5'd10, d8);
   endtask

   task automatic rd(logic [1:0] gs);
      rd_grp = gs; #1; g = rd_data;
   endtask

   task automatic strobe_rx(logic [7:0] b);
      @(negedge clk); rx_push = 1'b1; rx_byte = b;
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic strobe_tick();
      @(negedge clk); tmr_tick = 1'b1;
      @(negedge clk); tmr_tick = 1'b0;
   endtask

   task automatic strobe_take();
      @(negedge clk); tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      summary();
   end

   initial begin
      rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_grp = 0;
      rx_push = 0; rx_byte = 0; tx_take = 0; xsr_empty = 1; tmr_tick = 0;
      cts_in = 0; dsr_in = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd(2'd3); chk("R1 grp3", g, 8'h40);
      rd(2'd2); chk("R1 grp2", g, 8'hC0);
      chk("R1 irq/rts/brk", {irq, rts_en, brk_req}, 3'b000);

      // R2 priority stepping, R3, R4, R5, R6
      wbyte(8'hA5);
      chk("R2 ctrl first", ctrl_q, 8'hA5);
      chk("R3 no reload on ctrl", p_rl, 1'b0);
      wbyte(8'h3C);
      chk("R2 intv second", intv_q, 8'h3C);
      chk("R4 reload pulse", p_rl, 1'b1);
      @(negedge clk); chk("R4 reload one cycle", tmr_reload, 1'b0);
      wrate(10'h2D7, 1'b1);
      chk("R5 both rates", {rx_rate_q, tx_rate_q}, {10'h2D7, 10'h2D7});
      chk("R5 both div8", {rx_div8_q, tx_div8_q}, 2'b11);
      rd(2'd3); chk("R5 flags retired", g[6], 1'b0);
      wbyte(8'h96);
      chk("R2 txbuf last", txbuf_q, 8'h96);
      chk("R6 tx_req pulse", p_tx, 1'b1);
      rd(2'd2); chk("R6 buffer full", g[6], 1'b0);
      @(negedge clk); chk("R6 tx_req one cycle", tx_req, 1'b0);
      chk("R2 ctrl kept", ctrl_q, 8'hA5);
      wr(5'd9, 1'b1);
      chk("R2 txbuf ignores 9", {txbuf_q, tx_rate_q}, {8'h96, 10'h2D7});

      // R2 sweep: transmit buffer and control with many values
      for (int i = 0; i < 32; i++) begin
         logic [7:0] v;
         v = 8'(i * 37 + 11);
         strobe_take();
         wbyte(v);
         chk("R2 txbuf sweep", txbuf_q, v);
         chk("R6 sweep pulse", p_tx, 1'b1);
         wr(5'd14, 1'b1);
         wbyte(~v);
         chk("R2 ctrl sweep", {ctrl_q, txbuf_q}, {~v, v});
         chk("R3 sweep retire", p_tx, 1'b0);
      end
      strobe_take();
      rd(2'd2); chk("R13 take empties", g[6], 1'b1);

      // R7 flag writes, R5 single rate
      wr(5'd12, 1'b1);
      rd(2'd3); chk("R7 rx flag set", g[6], 1'b1);
      wrate(10'h155, 1'b0);
      chk("R5 rx only", {rx_rate_q, rx_div8_q, tx_rate_q, tx_div8_q}, {10'h155, 1'b0, 10'h2D7, 1'b1});
      wr(5'd13, 1'b1); chk("R7 set intv no pulse", p_rl, 1'b0);
      wr(5'd13, 1'b0); chk("R7 clear intv pulse", p_rl, 1'b1);
      wr(5'd13, 1'b0); chk("R7 clear idle no pulse", p_rl, 1'b0);
      wr(5'd11, 1'b1); rd(2'd3); chk("R7 tx flag set", g[6], 1'b1);
      wr(5'd11, 1'b0); rd(2'd3); chk("R7 tx flag clear", g[6], 1'b0);

      // R8 modem and break
      wr(5'd16, 1'b1); rd(2'd3); chk("R8 rts", {rts_en, g[2]}, 2'b11);
      wr(5'd17, 1'b1); chk("R8 brk", brk_req, 1'b1);
      wr(5'd16, 1'b0); wr(5'd17, 1'b0);
      chk("R8 cleared", {rts_en, brk_req}, 2'b00);

      // R13, R14 receive, timer, status change
      strobe_rx(8'h5A);
      rd(2'd0); chk("R14 rx byte", g, 8'h5A);
      rd(2'd2); chk("R13 loaded", g[5], 1'b1);
      rd(2'd1); chk("R14 no overrun", g, 8'h00);
      strobe_rx(8'hC3);
      rd(2'd0); chk("R14 rx byte 2", g, 8'hC3);
      rd(2'd1); chk("R13 overrun", g, 8'h0A);
      wr(5'd18, 1'b0);
      rd(2'd1); chk("R8 18 clears overrun", g, 8'h00);
      rd(2'd2); chk("R8 18 clears loaded", g[5], 1'b0);
      strobe_tick(); rd(2'd3); chk("R13 elapsed", g[1:0], 2'b10);
      strobe_tick(); rd(2'd3); chk("R13 timer error", g[1:0], 2'b11);
      wr(5'd20, 1'b0); rd(2'd3); chk("R8 20 clears timer", g[1:0], 2'b00);
      @(negedge clk); cts_in = 1'b1;
      @(negedge clk); rd(2'd3); chk("R13 cts change", g[5:4], 2'b11);
      wr(5'd21, 1'b0); rd(2'd3); chk("R8 21 clears dsch", g[5], 1'b0);
      @(negedge clk); dsr_in = 1'b1;
      @(negedge clk); rd(2'd3); chk("R13 dsr change", {g[5], g[3]}, 2'b11);
      @(negedge clk); dsr_in = 1'b0;
      @(negedge clk);

      // R10 R11 R12 exhaustive enable sweep
      for (int m = 0; m < 16; m++) begin
         wr(5'd18, m[0]); wr(5'd19, m[1]); wr(5'd20, m[2]); wr(5'd21, m[3]);
         strobe_rx(8'(m));
         strobe_tick();
         @(negedge clk); cts_in = ~cts_in;
         @(negedge clk);
         chk("R12 irq", irq, |m[3:0]);
         rd(2'd2);
         chk("R10 grp2", g, {3'b111, m[3], m[2], 1'b0, m[1], m[0]});
         rd(2'd3);
         chk("R11 grp3", g, {|m[3:0], 1'b0, 1'b1, cts_in, 1'b0, 1'b0, 1'b1, 1'b0});
      end

      // R9 soft reset
      wbyte(8'h77);
      wr(5'd16, 1'b1); wr(5'd17, 1'b1);
      rd(2'd2); chk("R9 pre full", g[6], 1'b0);
      wr(5'd31, 1'b1);
      rd(2'd3); chk("R9 flags and irq", {g[7], g[6], g[2]}, 3'b010);
      rd(2'd2); chk("R9 grp2", {g[6], g[5], g[4], g[3], g[1], g[0]}, 6'b100000);
      chk("R9 rts brk irq", {rts_en, brk_req, irq}, 3'b000);
      wbyte(8'h12);
      chk("R9 ctrl selected again", ctrl_q, 8'h12);

      summary();
   end
endmodule